// File: doc/BRIEF.md
# Reloading System Tick Timer

A periodic tick source built around a down counter that is 24 bits wide. Software loads a reload value, clears the current count and then enables the timer. From then on the counter steps down once per tick and refills itself from the reload value whenever it has reached zero. Each step from 1 to 0 sets a sticky flag in the control word. If the tick interrupt is enabled, the same step also produces a one-cycle pulse on the interrupt line. The count source is either every core clock or one core clock in eight. The slower rate comes from an internal enable strobe, so the block runs on a single clock.

Access is through a simple synchronous port. A select strobe with write high updates a register on the clock edge. With write low, the read data is valid in the same cycle, and a read of the control word clears the sticky flag at the edge that ends the access.

A small state machine governs the counter. In `ST_IDLE` the counter is stopped. In `ST_RUN` it steps on every tick. `ST_PARKED` means the timer is enabled while both the reload value and the count are zero, so no ticks happen.

The transitions are as follows:
- A control write with the enable bit set moves the machine from `ST_IDLE` to `ST_RUN`.
- From `ST_RUN`, the machine moves to `ST_PARKED` when the next count and the reload value are both zero.
- From `ST_PARKED`, it returns to `ST_RUN` once the reload value is non-zero.
- A control write with the enable bit clear moves either active state back to `ST_IDLE`.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word, the reload value and the current count all read 0, and the interrupt output is low.
- R2: The register address is decoded as follows:
  - Address 0 is the control word. Bit 0 is enable, bit 1 is tick-interrupt enable, bit 2 is the count source (1 for every clock, 0 for one clock in eight), and bit 16 is the read-only count flag. All other bits read 0.
  - Address 1 holds a 24-bit reload value; its upper bits read 0.
  - Address 3 reads 0.
- R3: With enable and the count source both set to 1, the count changes on every clock edge after the enabling write: a count of 0 loads the reload value, and any other count decrements by 1.
- R4: With the count source set to 0, one step happens every 8 clocks. The first step lands on the 8th edge after the enabling write.
- R5: A reload value N gives a wrap period of N+1 ticks.
- R6: A step from 1 to 0 sets the count flag. A read of the control word returns the flag and then clears it. If a read coincides with a new step from 1 to 0, the flag stays set.
- R7: Each step from 1 to 0 with interrupt enable set drives a one-cycle high pulse on `tick_irq`, in the cycle after that edge. No pulse occurs with interrupt enable clear.
- R8: A write of any value to address 2 sets the count to 0 and clears the count flag.
- R9: With a reload value of 0 and a count of 0, the enabled timer produces no steps, no flag and no pulse.
- R10: While enable is clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| tick_irq | output | 1 | One-cycle tick interrupt pulse |

## Verification
The hardest case to reach from the ports is a control read that lands on the same edge as a 1-to-0 step. In that case the flag must survive the read. The bench produces this case by counting clock edges from a known enabling write, with the count cleared and the reload value at 4. It starts the read exactly four cycles later. The first read must show the old, cleared flag, and an immediate second read must show the flag set. A second case is the divide-by-8 timing, which is checked by watching the interrupt across 16 edges. A third is the parked state, which is checked by running for many cycles with no pulse and no flag.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_PARKED = 2'd2
    } tmr_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 16;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic full_rate,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (full_rate || (phase_q == LAST));
endmodule

// File: rtl/tick_core.sv
module tick_core
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_we,
    input  logic             en_bit,
    input  logic             count_we,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output tmr_state_e       state,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             stepping;

    assign stepping = (state_q == ST_RUN) && tick && !count_we;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_we && en_bit) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (ctrl_we && !en_bit)                         state_d = ST_IDLE;
                else if (reload == '0 && count_d == '0)         state_d = ST_PARKED;
            end
            ST_PARKED: begin
                if (ctrl_we && !en_bit)  state_d = ST_IDLE;
                else if (reload != '0)   state_d = ST_RUN;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // counter outputs
    always_comb begin
        count_d = count_q;
        wrap    = 1'b0;
        if (count_we) begin
            count_d = '0;
        end else if (stepping) begin
            if (count_q == '0) begin
                count_d = reload;
            end else begin
                count_d = count_q - ONE;
                wrap    = (count_q == ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    assign count = count_q;
    assign state = state_q;
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              enabled,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic              ctrl_we,
    output logic              count_we,
    output logic              irq_en,
    output logic              full_rate,
    output logic [CNT_W-1:0]  reload,
    output logic              flag,
    output logic              irq
);
    logic ctrl_rd, reload_we;

    assign ctrl_we   = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign ctrl_rd   = bus_sel && !bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign reload_we = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(ADDR_RELOAD));
    assign count_we  = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(ADDR_COUNT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_en    <= 1'b0;
            full_rate <= 1'b0;
            reload    <= '0;
            flag      <= 1'b0;
            irq       <= 1'b0;
        end else begin
            if (ctrl_we) begin
                irq_en    <= bus_wdata[CTRL_IE_BIT];
                full_rate <= bus_wdata[CTRL_SRC_BIT];
            end
            if (reload_we) reload <= bus_wdata[CNT_W-1:0];
            if (wrap)                      flag <= 1'b1;
            else if (count_we || ctrl_rd)  flag <= 1'b0;
            irq <= wrap && irq_en;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_W'(ADDR_CTRL): begin
                bus_rdata[CTRL_EN_BIT]   = enabled;
                bus_rdata[CTRL_IE_BIT]   = irq_en;
                bus_rdata[CTRL_SRC_BIT]  = full_rate;
                bus_rdata[CTRL_FLAG_BIT] = flag;
            end
            ADDR_W'(ADDR_RELOAD): bus_rdata[CNT_W-1:0] = reload;
            ADDR_W'(ADDR_COUNT):  bus_rdata[CNT_W-1:0] = count;
            default:              bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int DIV    = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              tick_irq
);
    logic             ctrl_we, count_we, irq_en, full_rate, flag, wrap, tick;
    logic             running, enabled;
    logic [CNT_W-1:0] reload, count;
    tmr_state_e       state;

    assign running = (state == ST_RUN);
    assign enabled = (state != ST_IDLE);

    tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .enabled(enabled), .count(count), .wrap(wrap),
        .ctrl_we(ctrl_we), .count_we(count_we), .irq_en(irq_en),
        .full_rate(full_rate), .reload(reload), .flag(flag), .irq(tick_irq)
    );

    tick_prescaler #(.DIV(DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(running),
        .full_rate(full_rate), .tick(tick)
    );

    tick_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .en_bit(bus_wdata[CTRL_EN_BIT]),
        .count_we(count_we), .reload(reload), .tick(tick),
        .count(count), .state(state), .wrap(wrap)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             flag,
    input logic             running,
    input logic             enabled,
    input logic             count_we,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload
);
    // R7: a pulse lasts one cycle and marks a count that has just reached zero
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r7_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0));
    // R6: the flag only rises together with a count of zero
    a_r6_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (count == '0));
    // R10: a disabled timer keeps its count unless software clears it
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !count_we) |=> $stable(count));
    // R9: zero reload and zero count stay at zero
    a_r9_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && reload == '0) |=> (count == '0));
    // R3: running counter never jumps above the reload value from zero
    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !count_we && count == '0 && $stable(reload)) |=> (count == '0 || count == reload));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(tick_irq), .flag(flag),
    .running(running), .enabled(enabled), .count_we(count_we),
    .count(count), .reload(reload)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tick_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .tick_irq(tick_irq)
    );

    // {addr, write data, expected read-back}
    localparam logic [65:0] VEC [7] = '{
        {2'd1, 32'h0012_3456, 32'h0012_3456},
        {2'd1, 32'hFFFF_FFFF, 32'h00FF_FFFF},
        {2'd1, 32'h0000_0000, 32'h0000_0000},
        {2'd0, 32'h0000_0006, 32'h0000_0006},
        {2'd0, 32'hFFFF_FFF8, 32'h0000_0000},
        {2'd0, 32'h0000_0000, 32'h0000_0000},
        {2'd2, 32'h00AB_CDEF, 32'h0000_0000}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        rd(a, v);
        check(v === exp, req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        bit seen;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check(tick_irq === 1'b0, "R1 irq", {31'd0, tick_irq}, 32'd0);
        rd_chk(2'd0, 32'h0, "R1 ctrl");
        rd_chk(2'd1, 32'h0, "R1 reload");
        rd_chk(2'd2, 32'h0, "R1 count");
        rd_chk(2'd3, 32'h0, "R2 unused address");

        // R2 / R8 register table
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][65:64], VEC[i][63:32]);
            rd_chk(VEC[i][65:64], VEC[i][31:0], (VEC[i][65:64] == 2'd2) ? "R8 count write" : "R2 readback");
        end

        // R3 R5 R7 full rate, reload 4
        wr(2'd1, 32'd4); wr(2'd2, 32'd0); wr(2'd0, 32'h7);
        idle(4);
        check(tick_irq === 1'b0, "R7 no early pulse", {31'd0, tick_irq}, 32'd0);
        idle(1);
        check(tick_irq === 1'b1, "R3 R7 pulse after fifth edge", {31'd0, tick_irq}, 32'd1);
        idle(1);
        check(tick_irq === 1'b0, "R7 one cycle", {31'd0, tick_irq}, 32'd0);
        idle(4);
        check(tick_irq === 1'b1, "R5 period 5", {31'd0, tick_irq}, 32'd1);
        wr(2'd0, 32'h4);
        rd_chk(2'd0, 32'h0001_0004, "R6 flag set");
        rd_chk(2'd0, 32'h0000_0004, "R6 flag cleared by read");

        // R6 read on the same edge as the wrap
        wr(2'd2, 32'd0); wr(2'd0, 32'h7);
        idle(4);
        rd_chk(2'd0, 32'h0000_0007, "R6 old flag");
        rd_chk(2'd0, 32'h0001_0007, "R6 set wins over read");
        wr(2'd0, 32'h0);
        rd_chk(2'd0, 32'h0, "R6 flag cleared");

        // R7 no pulse without interrupt enable; R8 count write clears flag
        wr(2'd1, 32'd2); wr(2'd2, 32'd0); wr(2'd0, 32'h5);
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (tick_irq) seen = 1'b1;
        end
        check(!seen, "R7 masked", {31'd0, seen}, 32'd0);
        wr(2'd0, 32'h4);
        wr(2'd2, 32'h55);
        rd_chk(2'd0, 32'h4, "R8 flag cleared by count write");
        rd_chk(2'd2, 32'h0, "R8 count zero");

        // R4 divide by 8, reload 1
        wr(2'd1, 32'd1); wr(2'd2, 32'd0); wr(2'd0, 32'h3);
        idle(15);
        check(tick_irq === 1'b0, "R4 no pulse at edge 15", {31'd0, tick_irq}, 32'd0);
        idle(1);
        check(tick_irq === 1'b1, "R4 pulse at edge 16", {31'd0, tick_irq}, 32'd1);
        wr(2'd0, 32'h0);
        rd_chk(2'd0, 32'h0001_0000, "R4 flag after slow wrap");

        // R3 R10 count values
        wr(2'd1, 32'd9); wr(2'd2, 32'd0); wr(2'd0, 32'h5); wr(2'd0, 32'h4);
        rd_chk(2'd2, 32'd9, "R3 load from zero");
        wr(2'd0, 32'h5); wr(2'd0, 32'h4);
        rd_chk(2'd2, 32'd8, "R3 decrement");
        idle(10);
        rd_chk(2'd2, 32'd8, "R10 hold while disabled");

        // R9 reload zero
        wr(2'd1, 32'd0); wr(2'd2, 32'd0); wr(2'd0, 32'h7);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (tick_irq) seen = 1'b1;
        end
        check(!seen, "R9 no pulse", {31'd0, seen}, 32'd0);
        rd_chk(2'd2, 32'd0, "R9 count stays zero");
        rd_chk(2'd0, 32'h7, "R9 no flag");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule